// File: doc/BRIEF.md
# HD Pixel Source Selector with Test Pattern and Vertical-Blanking Gate

This block sits in the pixel path of an HD video encoder, ahead of the converters. On every pixel it chooses what goes out. It can pass the incoming 4:4:4 YCrCb sample through, force black, or substitute an internal test pattern. The pattern is either a cross-hatch grid or a flat field. Its colour comes from three writable component registers, and those registers hold white after reset.

The block keeps a line counter, started by a frame strobe and advanced by a line strobe. It also keeps a pixel counter that counts valid pixels in each line. On vertical-blanking lines the output is black unless data insertion is enabled and the line falls inside the insertion window for the chosen standard. Inside that window the input is passed through. Software writes the mode word at any time, but the block applies it only at the next frame strobe. The output is registered, with a valid flag that stays aligned to the pixel.

Top module: `hd_pattern_mux`

## Requirements
- R1: After reset the output valid flag is 0 and the output is black (Y=64, Cr=512, Cb=512). The mode word reads 0, and the colour registers read Y=940, Cr=512, Cb=512.
- R2: When the applied mode bit 0 (pixel enable) is 0, every output pixel is black, whatever the input data is.
- R3: The test pattern appears only when mode bit 1 (pattern enable) and mode bit 0 are both 1. With bit 0 at 1 and bit 1 at 0, valid pixels on active lines pass the input through unchanged.
- R4: When mode bit 2 is 0 in pattern mode, a pixel takes the colour registers if its index within the line (counted from 0) or its line number is a multiple of 16. All other pixels are black.
- R5: When mode bit 2 is 1 in pattern mode, every active-line pixel takes the colour registers.
- R6: Register addresses 1, 2 and 3 hold the Y, Cr and Cb colour components. A write to them affects the very next pixel.
- R7: Lines are numbered from 1 at the frame strobe. Mode bit 4 selects the standard: 0 for interlaced, 1 for progressive. Lines below 21 (interlaced) or below 26 (progressive) are blanking lines. On blanking lines the output is black, except when mode bit 3 is 1 and the line lies in 7–20 (interlaced) or 6–25 (progressive). In that case the input passes through.
- R8: Mode bit 5 sets the polarity of the input valid strobe: 0 means active high and 1 means active low. The output valid flag is always active high.
- R9: The mode word is held at address 0 in bits 5:0. Bits above 5 always read back as 0, whatever value was written to them.
- R10: A mode write takes effect only at the next frame strobe. Until that strobe, the output follows the previously applied mode.
- R11: The output carries one register of latency. A cycle without a valid input pixel produces output valid 0 and black data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 Y, 2 Cr, 3 Cb |
| cfg_wdata | input | 10 | Register write data |
| cfg_rdata | output | 10 | Read data of the selected register |
| frame_start | input | 1 | Frame strobe: sets the line to 1 and applies the pending mode |
| line_start | input | 1 | Line strobe: advances the line number and clears the pixel index |
| in_valid | input | 1 | Pixel valid strobe, with polarity set by mode bit 5 |
| in_y | input | 10 | Input luma |
| in_cr | input | 10 | Input red-difference chroma |
| in_cb | input | 10 | Input blue-difference chroma |
| out_valid | output | 1 | Output pixel valid, active high |
| out_y | output | 10 | Output luma |
| out_cr | output | 10 | Output red-difference chroma |
| out_cb | output | 10 | Output blue-difference chroma |

## Verification
The assertions check several rules on every cycle:
- The output is black while pixel enable is off, on idle cycles, and on blanking lines when insertion is disabled.
- The applied mode changes only at a frame strobe.
- The reserved mode bits read as zero.

Some behaviour only the directed scenarios can show, because it depends on counted positions and programmed values:
- the exact hatch geometry;
- the boundaries of the insertion window for each standard;
- the active-low valid strobe;
- the colour-register values reaching the output.

// File: rtl/hd_pattern_mux.sv
module hd_pattern_mux #(
  parameter int DW             = 10,
  parameter int LW             = 11,
  parameter int HATCH_LOG2     = 4,
  parameter int I_VBI_FIRST    = 7,
  parameter int I_VBI_LAST     = 20,
  parameter int P_VBI_FIRST    = 6,
  parameter int P_VBI_LAST     = 25,
  parameter int I_ACTIVE_FIRST = 21,
  parameter int P_ACTIVE_FIRST = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cr,
  input  logic [DW-1:0] in_cb,
  output logic          out_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cr,
  output logic [DW-1:0] out_cb
);
  localparam int MW = 6;
  localparam int SH = DW - 8;
  localparam logic [DW-1:0] BLK_Y = DW'(16 << SH);
  localparam logic [DW-1:0] MID_C = DW'(128 << SH);
  localparam logic [DW-1:0] WHT_Y = DW'(235 << SH);

  logic [MW-1:0]         mode_reg, mode_act;
  logic [DW-1:0]         col_y, col_cr, col_cb;
  logic [LW-1:0]         line_cnt;
  logic [HATCH_LOG2-1:0] pix_cnt;

  wire pix_en  = mode_act[0];
  wire pat_en  = mode_act[1];
  wire solid   = mode_act[2];
  wire vbi_en  = mode_act[3];
  wire prog    = mode_act[4];
  wire vld     = in_valid ^ mode_act[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_reg <= '0;
      col_y    <= WHT_Y;
      col_cr   <= MID_C;
      col_cb   <= MID_C;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: mode_reg <= cfg_wdata[MW-1:0];
        2'd1: col_y    <= cfg_wdata;
        2'd2: col_cr   <= cfg_wdata;
        default: col_cb <= cfg_wdata;
      endcase
    end

  always_comb
    case (cfg_addr)
      2'd0: cfg_rdata = {{(DW-MW){1'b0}}, mode_reg};
      2'd1: cfg_rdata = col_y;
      2'd2: cfg_rdata = col_cr;
      default: cfg_rdata = col_cb;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           mode_act <= '0;
    else if (frame_start) mode_act <= mode_reg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           line_cnt <= '0;
    else if (frame_start) line_cnt <= LW'(1);
    else if (line_start)  line_cnt <= line_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         pix_cnt <= '0;
    else if (frame_start || line_start) pix_cnt <= '0;
    else if (vld)                       pix_cnt <= pix_cnt + 1'b1;

  wire [LW-1:0] act_first = prog ? LW'(P_ACTIVE_FIRST) : LW'(I_ACTIVE_FIRST);
  wire [LW-1:0] win_lo    = prog ? LW'(P_VBI_FIRST)    : LW'(I_VBI_FIRST);
  wire [LW-1:0] win_hi    = prog ? LW'(P_VBI_LAST)     : LW'(I_VBI_LAST);
  wire in_blank = line_cnt < act_first;
  wire in_win   = (line_cnt >= win_lo) && (line_cnt <= win_hi);
  wire on_grid  = (pix_cnt == '0) || (line_cnt[HATCH_LOG2-1:0] == '0);

  typedef enum logic [1:0] {S_BLACK, S_INPUT, S_COLOUR} src_t;
  src_t src;

  always_comb begin
    src = S_BLACK;
    if (vld && pix_en) begin
      if (in_blank)              src = (vbi_en && in_win) ? S_INPUT : S_BLACK;
      else if (!pat_en)          src = S_INPUT;
      else if (solid || on_grid) src = S_COLOUR;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= BLK_Y;
      out_cr    <= MID_C;
      out_cb    <= MID_C;
    end else begin
      out_valid <= vld;
      case (src)
        S_INPUT:  begin out_y <= in_y;  out_cr <= in_cr;  out_cb <= in_cb;  end
        S_COLOUR: begin out_y <= col_y; out_cr <= col_cr; out_cb <= col_cb; end
        default:  begin out_y <= BLK_Y; out_cr <= MID_C;  out_cb <= MID_C;  end
      endcase
    end
endmodule

// File: rtl/hd_pattern_mux_chk.sv
module hd_pattern_mux_chk #(
  parameter int DW             = 10,
  parameter int LW             = 11,
  parameter int I_ACTIVE_FIRST = 21,
  parameter int P_ACTIVE_FIRST = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_addr,
  input logic [DW-1:0] cfg_rdata,
  input logic          frame_start,
  input logic [5:0]    mode_act,
  input logic [LW-1:0] line_cnt,
  input logic          out_valid,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cr,
  input logic [DW-1:0] out_cb
);
  localparam logic [DW-1:0] BY = DW'(16 << (DW-8));
  localparam logic [DW-1:0] BC = DW'(128 << (DW-8));
  wire is_black = (out_y == BY) && (out_cr == BC) && (out_cb == BC);
  wire blank_line = line_cnt < (mode_act[4] ? LW'(P_ACTIVE_FIRST) : LW'(I_ACTIVE_FIRST));

  a_r2_disabled_black: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_act[0] |=> is_black);
  a_r11_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> is_black);
  a_r10_mode_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_act));
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd0) |-> (cfg_rdata[DW-1:6] == '0));
  a_r7_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_line && !mode_act[3]) |=> is_black);
endmodule

bind hd_pattern_mux hd_pattern_mux_chk #(
  .DW(DW), .LW(LW), .I_ACTIVE_FIRST(I_ACTIVE_FIRST), .P_ACTIVE_FIRST(P_ACTIVE_FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .frame_start(frame_start), .mode_act(mode_act), .line_cnt(line_cnt),
  .out_valid(out_valid), .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb)
);

// File: tb/sim_hd_pattern_mux.sv
`timescale 1ns/1ps
module sim_hd_pattern_mux;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [9:0] cfg_wdata = 0;
  logic [9:0] cfg_rdata;
  logic frame_start = 0, line_start = 0, in_valid = 0;
  logic [9:0] in_y = 0, in_cr = 0, in_cb = 0;
  logic out_valid; logic [9:0] out_y, out_cr, out_cb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hd_pattern_mux u0 (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .frame_start, .line_start, .in_valid, .in_y, .in_cr, .in_cb,
    .out_valid, .out_y, .out_cr, .out_cb);

  localparam logic [9:0] BY = 64, BC = 512, WY = 940;
  localparam logic [9:0] DY = 200, DCR = 300, DCB = 400;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic px_chk(string tag, logic ev, logic [9:0] ey, ecr, ecb);
    chk({tag, " valid"}, out_valid, ev);
    chk({tag, " y"}, out_y, ey);
    chk({tag, " cr"}, out_cr, ecr);
    chk({tag, " cb"}, out_cb, ecb);
  endtask

  task automatic cyc(logic fs, logic ls, logic v, logic [9:0] y, cr, cb);
    @(negedge clk);
    cfg_we = 0; frame_start = fs; line_start = ls; in_valid = v;
    in_y = y; in_cr = cr; in_cb = cb;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [9:0] d);
    @(negedge clk);
    frame_start = 0; line_start = 0; in_valid = 0;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [9:0] d);
    @(negedge clk);
    cfg_we = 0; frame_start = 0; line_start = 0; in_valid = 0; cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic goto_line(int n);
    cyc(1, 0, 0, 0, 0, 0);
    for (int i = 1; i < n; i++) cyc(0, 1, 0, 0, 0, 0);
  endtask

  task automatic pix(logic v); cyc(0, 0, v, DY, DCR, DCB); endtask

  task automatic t_reset;
    logic [9:0] d;
    px_chk("R1 reset out", 0, BY, BC, BC);
    rd(0, d); chk("R1 mode", d, 0);
    rd(1, d); chk("R1 col y", d, WY);
    rd(2, d); chk("R1 col cr", d, BC);
    rd(3, d); chk("R1 col cb", d, BC);
  endtask

  task automatic t_disable_and_sync;
    wr(0, 10'h000); goto_line(30);
    pix(1); px_chk("R2 disabled", 1, BY, BC, BC);
    wr(0, 10'h001);
    pix(1); px_chk("R10 pending mode", 1, BY, BC, BC);
    goto_line(30);
    pix(1); px_chk("R10 applied mode", 1, DY, DCR, DCB);
  endtask

  task automatic t_pass_latency;
    wr(0, 10'h001); goto_line(40);
    cyc(0, 0, 1, 10'd111, 10'd222, 10'd333);
    px_chk("R3 R11 first", 1, 111, 222, 333);
    cyc(0, 0, 1, 10'd444, 10'd555, 10'd666);
    px_chk("R11 second", 1, 444, 555, 666);
    pix(0); px_chk("R11 idle", 0, BY, BC, BC);
  endtask

  task automatic t_pattern_gate;
    wr(0, 10'h006); goto_line(30);
    pix(1); px_chk("R3 pattern no pix_en", 1, BY, BC, BC);
    wr(0, 10'h007); goto_line(30);
    pix(1); px_chk("R5 solid white", 1, WY, BC, BC);
    pix(1); px_chk("R5 solid second", 1, WY, BC, BC);
  endtask

  task automatic t_colour;
    wr(0, 10'h007); goto_line(50);
    wr(1, 10'd300); wr(2, 10'd100); wr(3, 10'd800);
    pix(1); px_chk("R6 colour", 1, 300, 100, 800);
    wr(1, WY); wr(2, BC); wr(3, BC);
    pix(1); px_chk("R6 colour restored", 1, WY, BC, BC);
  endtask

  task automatic t_hatch;
    wr(0, 10'h003); goto_line(30);
    for (int i = 0; i < 17; i++) begin
      pix(1);
      if (i == 0 || i == 16) px_chk("R4 grid column", 1, WY, BC, BC);
      if (i == 1 || i == 15) px_chk("R4 off grid", 1, BY, BC, BC);
    end
    cyc(0, 1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) pix(1);
    px_chk("R4 grid row", 1, WY, BC, BC);
  endtask

  task automatic t_vbi;
    wr(0, 10'h00F); goto_line(6);
    pix(1); px_chk("R7 i line6", 1, BY, BC, BC);
    cyc(0, 1, 0, 0, 0, 0); pix(1); px_chk("R7 i line7", 1, DY, DCR, DCB);
    for (int i = 8; i <= 20; i++) cyc(0, 1, 0, 0, 0, 0);
    pix(1); px_chk("R7 i line20", 1, DY, DCR, DCB);
    cyc(0, 1, 0, 0, 0, 0); pix(1); px_chk("R7 i line21 active", 1, WY, BC, BC);
    wr(0, 10'h007); goto_line(10);
    pix(1); px_chk("R7 vbi off", 1, BY, BC, BC);
    wr(0, 10'h01F); goto_line(5);
    pix(1); px_chk("R7 p line5", 1, BY, BC, BC);
    cyc(0, 1, 0, 0, 0, 0); pix(1); px_chk("R7 p line6", 1, DY, DCR, DCB);
    for (int i = 7; i <= 21; i++) cyc(0, 1, 0, 0, 0, 0);
    pix(1); px_chk("R7 p line21", 1, DY, DCR, DCB);
    for (int i = 22; i <= 25; i++) cyc(0, 1, 0, 0, 0, 0);
    pix(1); px_chk("R7 p line25", 1, DY, DCR, DCB);
    cyc(0, 1, 0, 0, 0, 0); pix(1); px_chk("R7 p line26 active", 1, WY, BC, BC);
  endtask

  task automatic t_polarity;
    wr(0, 10'h021); goto_line(30);
    pix(0); px_chk("R8 low is valid", 1, DY, DCR, DCB);
    pix(1); px_chk("R8 high is idle", 0, BY, BC, BC);
  endtask

  task automatic t_reserved;
    logic [9:0] d;
    wr(0, 10'h3FF); rd(0, d); chk("R9 reserved bits", d, 10'h03F);
    wr(0, 10'h3C0); rd(0, d); chk("R9 only reserved", d, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    #1;
    t_reset;
    t_disable_and_sync;
    t_pass_latency;
    t_pattern_gate;
    t_colour;
    t_hatch;
    t_vbi;
    t_polarity;
    t_reserved;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule